// File: doc/BRIEF.md
# Open-Page DRAM Bank Read Sequencer

This block takes read requests for one DRAM bank, each carrying a row and a column address, and turns them into a stream of bank commands: ACTIVATE, READ and PRECHARGE, with NOP on every idle cycle. It leaves the last activated row open after each request. A later request to that same row goes straight to READ. A request to a different row first closes the open row and then opens the new one. If no row is open, it opens the new row without closing anything.

Four cycle counts are programmable: the read latency (CAS), the activate-to-read delay, the precharge-to-activate delay, and the minimum time a row stays open. A command-rate option selects whether each command is held on the bus for one or two clocks. All of these are sampled when a request is accepted. Every command starts in the earliest cycle that the timing rules allow. The block raises a one-cycle data-valid strobe at the moment read data is due. With it comes a flag that says whether the request hit the open row.

Top module: `open_page_seq`

## Requirements
- R1: The data-valid strobe `rd_valid` is high for exactly one cycle. That cycle is CAS cycles after the last drive cycle of the READ command.
- R2: The first drive cycle of a READ is at least tRCD cycles after the last drive cycle of the ACTIVATE that opened its row.
- R3: The first drive cycle of an ACTIVATE is at least tRP cycles after the last drive cycle of the preceding PRECHARGE.
- R4: The first drive cycle of a PRECHARGE is at least tRASmin cycles after the last drive cycle of the ACTIVATE of the row being closed. The tRASmin used is the value that was in effect for that ACTIVATE.
- R5: The first drive cycles of two successive ACTIVATEs are separated by at least tRASmin + tRP cycles.
- R6: With `cfg_two_t`=1, every command is held with unchanged opcode, row and column for exactly two consecutive cycles. With `cfg_two_t`=0, every command is driven for one cycle.
- R7: Command sequences follow the open-row state. A hit issues READ only. A miss with a row open issues PRECHARGE, ACTIVATE, READ. A miss with no row open issues ACTIVATE, READ. After reset no row is open. ACTIVATE carries the request row on `cmd_row`, and READ carries the request column on `cmd_col`.
- R8: Configuration inputs are sampled only in the acceptance cycle, and changing them during a request has no effect on it. A configured count of 0 behaves as 1.
- R9: `req_ready` is high while idle and low from the cycle after acceptance through the strobe cycle. It is high again in the cycle after the strobe.
- R10: `rd_hit` is high in the strobe cycle exactly when the request's row equalled the open row at acceptance. It is low in every cycle without a strobe.
- R11: `cmd_op` uses NOP=0, ACTIVATE=1, READ=2, PRECHARGE=3, and shows NOP in every cycle with no command. After reset it shows NOP, `req_ready`=1 and `rd_valid`=0.
- R12: Each command starts in the earliest cycle the rules allow. The first command starts in the cycle after acceptance. The total latency from acceptance to strobe therefore follows exactly from the sampled counts and the open-row state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| cfg_cas | input | CNT_W | Read latency in cycles |
| cfg_act_to_rd | input | CNT_W | Activate-to-read delay (tRCD) |
| cfg_pre_to_act | input | CNT_W | Precharge-to-activate delay (tRP) |
| cfg_act_min | input | CNT_W | Minimum row-open time (tRASmin) |
| cfg_two_t | input | 1 | 1 selects two-clock command rate |
| cmd_op | output | 2 | Bank command opcode |
| cmd_row | output | ROW_W | Row carried by ACTIVATE, READ or PRECHARGE |
| cmd_col | output | COL_W | Column carried by READ |
| rd_valid | output | 1 | Read data due on the bus this cycle |
| rd_hit | output | 1 | Qualifies `rd_valid`: request hit the open row |

## Verification
The hardest case to reach is a PRECHARGE held back by tRASmin. It needs a miss that arrives soon after an activation, with a long minimum-open time and short CAS and tRCD. That is the only way for the earlier activation to still be inside its window. Directed requests set up that pattern in both command rates. The random phase then draws rows from a set of four so that hits and misses interleave. Its counts are mostly small with occasional zeros and maximums, and it scrambles the configuration inputs while each request is in flight.

// File: rtl/ops_pkg.sv
// Package: shared command and state encodings for the open-page sequencer.
// Assumes a single bank; the opcode values are visible on the command port.
package ops_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_PRE = 2'd3
    } bank_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    // Index of each timing field in the packed configuration vector
    localparam int unsigned F_CAS  = 0;
    localparam int unsigned F_RCD  = 1;
    localparam int unsigned F_RP   = 2;
    localparam int unsigned F_RAS  = 3;
    localparam int unsigned NUM_F  = 4;

endpackage

// File: rtl/ops_cfg_latch.sv
// Module: captures the timing counts and command rate on request acceptance.
// A zero count is stored as one, so downstream timers never see zero.
// Assumes capture is asserted only while the sequencer is idle.
module ops_cfg_latch #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned NUM   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture,
    input  logic [NUM-1:0][CNT_W-1:0] raw,
    input  logic                      two_t_in,
    output logic [NUM-1:0][CNT_W-1:0] held,
    output logic                      two_t
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    for (genvar i = 0; i < NUM; i++) begin : g_field
        // Hold one clamped timing count per field
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[i] <= ONE;
            end else if (capture) begin
                held[i] <= (raw[i] == '0) ? ONE : raw[i];
            end
        end
    end

    // Hold the command-rate selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            two_t <= 1'b0;
        end else if (capture) begin
            two_t <= two_t_in;
        end
    end

endmodule

// File: rtl/ops_countdown.sv
// Module: loadable down-counter that reports when a timing window is over.
// Loading value V at the end of cycle I makes 'zero' true from cycle I+V on.
// Assumes load_val is never zero.
module ops_countdown #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load the window length minus one, then count down to zero and stay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ops_ctrl.sv
// Module: request FSM and command issue for one bank with an open-row policy.
// Picks READ, PRE+ACT+READ or ACT+READ from the open-row state. It drives each
// command for one or two cycles and starts it only when the gap timer (and,
// for PRECHARGE, the row-open timer) has expired.
// Assumes the timing inputs are latched, non-zero and stable during a request.
module ops_ctrl
    import ops_pkg::*;
#(
    parameter int unsigned ROW_W = 13,
    parameter int unsigned COL_W = 10,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             req_ready,
    input  logic             two_t,
    input  logic [CNT_W-1:0] t_cas,
    input  logic [CNT_W-1:0] t_rcd,
    input  logic [CNT_W-1:0] t_rp,
    input  logic             gap_zero,
    input  logic             ras_zero,
    output logic             cfg_capture,
    output logic             gap_load,
    output logic [CNT_W-1:0] gap_val,
    output logic             ras_load,
    output logic [1:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             rd_valid,
    output logic             rd_hit
);

    seq_state_e       state_q;
    bank_cmd_e        pend_q;
    logic             phase_q;
    logic             hit_q;
    logic             open_vld_q;
    logic [ROW_W-1:0] open_row_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    logic accept;
    logic req_is_hit;
    logic drive;
    logic issue;

    // Decide acceptance, hit, and whether the pending command drives this cycle
    always_comb begin
        accept     = (state_q == ST_IDLE) && req_valid;
        req_is_hit = open_vld_q && (req_row == open_row_q);
        drive      = (state_q == ST_CMD) &&
                     (phase_q || (gap_zero && ((pend_q != CMD_PRE) || ras_zero)));
        issue      = drive && (phase_q == two_t);
    end

    // Select the gap that follows the command being issued
    always_comb begin
        unique case (pend_q)
            CMD_PRE: gap_val = t_rp;
            CMD_ACT: gap_val = t_rcd;
            default: gap_val = t_cas;
        endcase
    end

    assign cfg_capture = accept;
    assign gap_load    = issue;
    assign ras_load    = issue && (pend_q == CMD_ACT);

    // Sequence the request through its commands and the data wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_q     <= CMD_NOP;
            phase_q    <= 1'b0;
            hit_q      <= 1'b0;
            open_vld_q <= 1'b0;
            open_row_q <= '0;
            row_q      <= '0;
            col_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        row_q   <= req_row;
                        col_q   <= req_col;
                        hit_q   <= req_is_hit;
                        phase_q <= 1'b0;
                        state_q <= ST_CMD;
                        if (req_is_hit)      pend_q <= CMD_RD;
                        else if (open_vld_q) pend_q <= CMD_PRE;
                        else                 pend_q <= CMD_ACT;
                    end
                end
                ST_CMD: begin
                    if (drive) begin
                        phase_q <= !issue;
                    end
                    if (issue) begin
                        unique case (pend_q)
                            CMD_PRE: begin
                                pend_q     <= CMD_ACT;
                                open_vld_q <= 1'b0;
                            end
                            CMD_ACT: begin
                                pend_q     <= CMD_RD;
                                open_vld_q <= 1'b1;
                                open_row_q <= row_q;
                            end
                            default: begin
                                pend_q  <= CMD_NOP;
                                state_q <= ST_DATA;
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    if (gap_zero) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Present the command bus and the data strobe
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cmd_op    = drive ? pend_q : CMD_NOP;
        cmd_row   = '0;
        cmd_col   = '0;
        if (drive) begin
            cmd_row = (pend_q == CMD_PRE) ? open_row_q : row_q;
            if (pend_q == CMD_RD) cmd_col = col_q;
        end
        rd_valid  = (state_q == ST_DATA) && gap_zero;
        rd_hit    = rd_valid && hit_q;
    end

endmodule

// File: rtl/open_page_seq.sv
// Module: top of the single-bank open-page read sequencer.
// Latches the timing set at acceptance, runs one gap timer shared by all
// command-to-command delays and CAS, plus one row-open timer for tRASmin.
// Assumes one outstanding request at a time.
module open_page_seq
    import ops_pkg::*;
#(
    parameter int unsigned ROW_W = 13,
    parameter int unsigned COL_W = 10,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [CNT_W-1:0] cfg_cas,
    input  logic [CNT_W-1:0] cfg_act_to_rd,
    input  logic [CNT_W-1:0] cfg_pre_to_act,
    input  logic [CNT_W-1:0] cfg_act_min,
    input  logic             cfg_two_t,
    output logic [1:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             rd_valid,
    output logic             rd_hit
);

    logic [NUM_F-1:0][CNT_W-1:0] cfg_raw;
    logic [NUM_F-1:0][CNT_W-1:0] cfg_held;
    logic                        two_t_q;
    logic [CNT_W-1:0]            cas_q, trcd_q, trp_q, tras_q;
    logic                        cfg_capture;
    logic                        gap_load, gap_zero;
    logic [CNT_W-1:0]            gap_val;
    logic                        ras_load, ras_zero;

    // Pack the raw inputs and unpack the held counts by field index
    always_comb begin
        cfg_raw[F_CAS] = cfg_cas;
        cfg_raw[F_RCD] = cfg_act_to_rd;
        cfg_raw[F_RP]  = cfg_pre_to_act;
        cfg_raw[F_RAS] = cfg_act_min;
        cas_q  = cfg_held[F_CAS];
        trcd_q = cfg_held[F_RCD];
        trp_q  = cfg_held[F_RP];
        tras_q = cfg_held[F_RAS];
    end

    ops_cfg_latch #(.CNT_W(CNT_W), .NUM(NUM_F)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (cfg_capture),
        .raw      (cfg_raw),
        .two_t_in (cfg_two_t),
        .held     (cfg_held),
        .two_t    (two_t_q)
    );

    ops_countdown #(.CNT_W(CNT_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    ops_countdown #(.CNT_W(CNT_W)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ras_load),
        .load_val (tras_q),
        .zero     (ras_zero)
    );

    ops_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_row     (req_row),
        .req_col     (req_col),
        .req_ready   (req_ready),
        .two_t       (two_t_q),
        .t_cas       (cas_q),
        .t_rcd       (trcd_q),
        .t_rp        (trp_q),
        .gap_zero    (gap_zero),
        .ras_zero    (ras_zero),
        .cfg_capture (cfg_capture),
        .gap_load    (gap_load),
        .gap_val     (gap_val),
        .ras_load    (ras_load),
        .cmd_op      (cmd_op),
        .cmd_row     (cmd_row),
        .cmd_col     (cmd_col),
        .rd_valid    (rd_valid),
        .rd_hit      (rd_hit)
    );

endmodule

// File: rtl/open_page_seq_chk.sv
// Checker: timestamps command edges on the bus and checks spacing, hold and
// handshake rules. Attached to every open_page_seq instance by bind.
module open_page_seq_chk
    import ops_pkg::*;
#(
    parameter int unsigned ROW_W = 13,
    parameter int unsigned COL_W = 10,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       cmd_op,
    input logic [ROW_W-1:0] cmd_row,
    input logic [COL_W-1:0] cmd_col,
    input logic             rd_valid,
    input logic             rd_hit,
    input logic             two_t_q,
    input logic [CNT_W-1:0] trcd_q,
    input logic [CNT_W-1:0] trp_q,
    input logic [CNT_W-1:0] tras_q
);

    localparam int unsigned AGE_W = 6;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [1:0]       prev_op;
    logic [AGE_W-1:0] act_age, pre_age;
    logic [CNT_W-1:0] act_rcd, act_ras, pre_rp;
    logic             starting;

    assign starting = (cmd_op != CMD_NOP) && (cmd_op != prev_op);

    // Track cycles since the last ACT and PRE drive cycle and their windows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_op <= CMD_NOP;
            act_age <= AGE_MAX;
            pre_age <= AGE_MAX;
            act_rcd <= '0;
            act_ras <= '0;
            pre_rp  <= '0;
        end else begin
            prev_op <= cmd_op;
            if (cmd_op == CMD_ACT) begin
                act_age <= AGE_W'(1);
                act_rcd <= trcd_q;
                act_ras <= tras_q;
            end else if (act_age != AGE_MAX) begin
                act_age <= act_age + AGE_W'(1);
            end
            if (cmd_op == CMD_PRE) begin
                pre_age <= AGE_W'(1);
                pre_rp  <= trp_q;
            end else if (pre_age != AGE_MAX) begin
                pre_age <= pre_age + AGE_W'(1);
            end
        end
    end

    assert_rd_after_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (starting && cmd_op == CMD_RD) |-> (act_age >= AGE_W'(act_rcd)));

    assert_act_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (starting && cmd_op == CMD_ACT) |-> (pre_age >= AGE_W'(pre_rp)));

    assert_pre_after_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (starting && cmd_op == CMD_PRE) |-> (act_age >= AGE_W'(act_ras)));

    assert_hold_two_cycles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (two_t_q && starting) |=> ($stable(cmd_op) && $stable(cmd_row) && $stable(cmd_col)));

    assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_t_q && cmd_op != CMD_NOP) |=> (cmd_op != $past(cmd_op)));

    assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_ready_low_at_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);

    assert_hit_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> rd_valid);

endmodule

bind open_page_seq open_page_seq_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_op    (cmd_op),
    .cmd_row   (cmd_row),
    .cmd_col   (cmd_col),
    .rd_valid  (rd_valid),
    .rd_hit    (rd_hit),
    .two_t_q   (two_t_q),
    .trcd_q    (trcd_q),
    .trp_q     (trp_q),
    .tras_q    (tras_q)
);

// File: tb/tb_open_page_seq.sv
// Bench: directed corner cases then seeded random requests. An independent
// cycle model computes the command schedule, strobe cycle and hit flag.
module tb_open_page_seq;

    localparam int ROW_W = 13;
    localparam int COL_W = 10;
    localparam int CNT_W = 4;
    localparam int OP_NOP = 0, OP_ACT = 1, OP_RD = 2, OP_PRE = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [CNT_W-1:0] cfg_cas = '0, cfg_act_to_rd = '0, cfg_pre_to_act = '0, cfg_act_min = '0;
    logic             cfg_two_t = 1'b0;
    logic [1:0]       cmd_op;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic             rd_valid, rd_hit;

    open_page_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int  cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_checks = 0, n_fail = 0;
    bit  done = 1'b0;

    // Reference model state
    bit  m_open = 1'b0;
    int  m_open_row = 0;
    int  m_act_iss = 0;
    int  m_act_ras = 1;
    int  m_prev_act_start = -1;
    int  m_prev_act_ras = 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Issue one request and check everything it produces up to the cycle after the strobe
    task automatic do_req(input int row, input int col, input int cl_in, input int rcd_in,
                          input int rp_in, input int ras_in, input bit two);
        int a, n, t, st_pre, st_act, st_rd, v, cl, rcd, rp, ras;
        int exp_op, exp_row, exp_col, bad, first_act, first_exp, ready_bad, strobe_bad;
        bit hit, prev_open;
        req_valid      = 1'b1;
        req_row        = ROW_W'(row);
        req_col        = COL_W'(col);
        cfg_cas        = CNT_W'(cl_in);
        cfg_act_to_rd  = CNT_W'(rcd_in);
        cfg_pre_to_act = CNT_W'(rp_in);
        cfg_act_min    = CNT_W'(ras_in);
        cfg_two_t      = two;
        while (!req_ready) @(negedge clk);
        a = cyc;
        cl = clamp1(cl_in); rcd = clamp1(rcd_in); rp = clamp1(rp_in); ras = clamp1(ras_in);
        n = two ? 2 : 1;
        prev_open = m_open;
        hit = m_open && (m_open_row == row);
        t = a + 1;
        st_pre = -100; st_act = -100;
        if (!hit && prev_open) begin
            st_pre = max2(t, m_act_iss + m_act_ras);
            t = st_pre + n - 1 + rp;
        end
        if (!hit) begin
            st_act = t;
            m_act_iss = st_act + n - 1;
            m_act_ras = ras;
            t = m_act_iss + rcd;
        end
        st_rd = t;
        v = st_rd + n - 1 + cl;
        m_open = 1'b1;
        m_open_row = row;

        @(negedge clk);
        req_valid = 1'b0;
        // R8: scramble configuration while the request is in flight
        cfg_cas        = CNT_W'($urandom);
        cfg_act_to_rd  = CNT_W'($urandom);
        cfg_pre_to_act = CNT_W'($urandom);
        cfg_act_min    = CNT_W'($urandom);
        cfg_two_t      = ~two;
        req_row        = ROW_W'($urandom);

        bad = 0; first_act = 0; first_exp = 0; ready_bad = 0; strobe_bad = 0;
        for (int c = a + 1; c <= v; c++) begin
            exp_op = OP_NOP; exp_row = 0; exp_col = 0;
            if (c >= st_pre && c < st_pre + n) begin exp_op = OP_PRE; exp_row = -1; end
            if (c >= st_act && c < st_act + n) begin exp_op = OP_ACT; exp_row = row; end
            if (c >= st_rd  && c < st_rd  + n) begin exp_op = OP_RD;  exp_row = -1; exp_col = col; end
            if (int'(cmd_op) != exp_op ||
                (exp_op == OP_ACT && int'(cmd_row) != exp_row) ||
                (exp_op == OP_RD && int'(cmd_col) != exp_col)) begin
                if (bad == 0) begin first_act = int'(cmd_op); first_exp = exp_op; end
                bad++;
            end
            // R5: spacing of successive ACTIVATE first drive cycles
            if (cmd_op == 2'(OP_ACT) && c == st_act) begin
                if (m_prev_act_start >= 0)
                    check(c - m_prev_act_start >= m_prev_act_ras + rp, "R5", "ACT-to-ACT spacing",
                          c - m_prev_act_start, m_prev_act_ras + rp);
                m_prev_act_start = c;
                m_prev_act_ras = ras;
            end
            if (req_ready) ready_bad++;
            if (c < v && rd_valid) strobe_bad++;
            if (c == v) begin
                check(rd_valid == 1'b1, "R1/R12", "strobe at modelled cycle", int'(rd_valid), 1);
                check(rd_hit == hit, "R10", "hit flag", int'(rd_hit), int'(hit));
            end
            if (c < v) @(negedge clk);
        end
        check(bad == 0, "R7/R2/R3/R4/R6/R12", "command schedule opcode", first_act, first_exp);
        check(strobe_bad == 0, "R1", "early strobe cycles", strobe_bad, 0);
        check(ready_bad == 0, "R9", "ready high while busy", ready_bad, 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R9", "ready after strobe", int'(req_ready), 1);
        check(rd_valid == 1'b0 && rd_hit == 1'b0, "R10", "no strobe or hit after strobe",
              int'(rd_valid) + int'(rd_hit), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        check(cmd_op == 2'(OP_NOP), "R11", "cmd in reset", int'(cmd_op), OP_NOP);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_op == 2'(OP_NOP) && req_ready == 1'b1 && rd_valid == 1'b0, "R11",
              "idle state after reset", int'(cmd_op) + 4 * int'(req_ready), 4);

        // First request after reset: ACT then READ, all counts zero -> one (R7, R8)
        do_req(5, 17, 0, 0, 0, 0, 1'b0);
        // Hit on the open row (R10, R1)
        do_req(5, 33, 3, 2, 2, 4, 1'b0);
        // Miss right away with a long tRASmin: PRE held back (R4)
        do_req(9, 2, 1, 1, 3, 15, 1'b0);
        do_req(1, 4, 1, 1, 1, 15, 1'b1);
        // Maximum counts in 2T mode (R6)
        do_req(2, 1023, 15, 15, 15, 15, 1'b1);
        do_req(2, 0, 15, 15, 15, 15, 1'b1);
        // Idle gap before a miss so tRASmin is already over
        repeat (20) @(negedge clk);
        do_req(3, 7, 2, 1, 1, 5, 1'b0);

        for (int i = 0; i < 250; i++) begin
            int sel;
            int cv[4];
            for (int k = 0; k < 4; k++) begin
                sel = int'($urandom_range(0, 9));
                cv[k] = (sel == 0) ? 0 : (sel == 9) ? 15 : int'($urandom_range(1, 6));
            end
            if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 8)) @(negedge clk);
            do_req(int'($urandom_range(0, 3)), int'($urandom_range(0, 1023)),
                   cv[0], cv[1], cv[2], cv[3], 1'($urandom_range(0, 1)));
        end
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
    end

endmodule